// File: doc/BRIEF.md
# Load-versus-Store Alias Guard

This block sits in the effective-address stage of a load/store unit and decides whether the load held in that stage may reach the data cache ahead of older stores that are still waiting to write. It keeps a four-entry in-order store queue. Each entry holds the untranslated page-offset bits of a store address (bits 11:0) and the store's size. Every cycle it compares the waiting load against every valid entry. The comparison looks only at the offset bits, because the upper address bits are not yet translated. It uses word granularity when both accesses are at most four bytes and double-word granularity otherwise. Because the page number is never seen, two different physical locations can be flagged as aliasing. Such a false match is accepted and stalls the load like a real one.

When nothing matches, the load takes the single cache port and passes the stores. When something matches, the load is held in the stage until every matching store has drained. How the hold happens depends on how long the load has been in the stage. A load that arrived this cycle is detected too late: its cache access goes out anyway, the store is kept off the port, and the load is canceled in the next cycle. A load that has been waiting longer is blocked before it reaches the cache, and the store drains in the same cycle. Stores enter through a valid/ready push port and leave through a valid/ready drain port. Push back-pressure comes only from a full queue. A drain holds its head entry for as long as the cache keeps ready low, for example on a miss.

Top module: `ald_guard`

## Requirements
- R1: After reset the queue is empty, `st_in_ready` is 1, and `st_out_valid`, `ld_stall`, `ld_cancel` and `ld_cache_go` are all 0.
- R2: The queue holds up to 4 stores. A push is taken only when `st_in_valid` and `st_in_ready` are both 1, and `st_in_ready` is 0 while 4 entries are held. Stores drain in push order. A store pushed at one clock edge joins the alias comparison from the next cycle.
- R3: `st_out_valid` is 1 exactly when the queue is non-empty and `ld_cache_go` is 0 in that cycle, so the load and a store never hold the cache port together. The head entry stays presented, unchanged, until a cycle with `st_out_valid` and `st_out_ready` both 1.
- R4: Only address bits 11:0 are compared. With size codes 0, 1 and 2 (1, 2 and 4 bytes) on both sides, the two offsets are compared under mask 0xFFC. So 0x2000 and 0x3003 alias, and 0x2000 and 0x2020 do not.
- R5: If either the load or the store carries size code 3 (8 bytes), the offsets are compared under mask 0xFF8.
- R6: A valid load that matches no valid entry has `ld_cache_go`=1 and `ld_stall`=0, whatever is queued ahead of it.
- R7: A matching load that has been in the stage for two or more cycles has `ld_stall`=1 and `ld_cache_go`=0, and the queue head drains in that same cycle.
- R8: A matching load in its first cycle in the stage (`ld_new`=1) has `ld_cache_go`=1, `ld_stall`=1 and `st_out_valid`=0. In the following cycle `ld_cancel`=1.
- R9: `ld_stall` stays 1 while any valid entry matches the load, including while a store miss holds the head. It drops in the cycle after the last matching entry drains.
- R10: A load is canceled at most once. The stage age counts 1 on the `ld_new` cycle, saturates at 3, and holds while `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load occupies the effective-address stage |
| ld_new | input | 1 | This is the load's first cycle in the stage |
| ld_addr | input | 12 | Load address bits 11:0 |
| ld_size | input | 2 | Load size code (0:1B 1:2B 2:4B 3:8B) |
| st_in_valid | input | 1 | Store push request |
| st_in_ready | output | 1 | Queue can accept a store |
| st_in_addr | input | 12 | Pushed store address bits 11:0 |
| st_in_size | input | 2 | Pushed store size code |
| st_out_valid | output | 1 | Head store offered to the cache port |
| st_out_ready | input | 1 | Cache completed the head store |
| st_out_addr | output | 12 | Head store address bits 11:0 |
| st_out_size | output | 2 | Head store size code |
| ld_cache_go | output | 1 | Load drives the cache port this cycle |
| ld_stall | output | 1 | Load must stay in the stage |
| ld_cancel | output | 1 | Discard the load's cache access from the previous cycle |

## Verification
The bench targets the two timing paths: a match found in the load's first cycle and a match found after it has waited. A design that mixes them up would either let a stale load read the cache without a cancel, or cancel a load that never reached the cache. It also exercises both mask widths with the 0x2000/0x3003 and 0x2000/0x2020 pairs and with mixed 4- and 8-byte pairs. A wrong mask shows up as a missed stall or a needless one. Finally, it holds `st_out_ready` low behind a matching store, fills the queue to its limit, and runs long random traffic. These catch a load released before its store is gone, a lost or reordered store, and a push accepted while the queue is full.

// File: rtl/ald_pkg.sv
package ald_pkg;
  localparam int OFF_W  = 12;
  localparam int SIZE_W = 2;

  localparam logic [SIZE_W-1:0] SZ_DWORD = 2'd3;

  localparam logic [OFF_W-1:0] MASK_WORD  = 12'hFFC;
  localparam logic [OFF_W-1:0] MASK_DWORD = 12'hFF8;

  typedef struct packed {
    logic [OFF_W-1:0]  addr;
    logic [SIZE_W-1:0] size;
  } st_ent_t;
endpackage

// File: rtl/ald_store_fifo.sv
module ald_store_fifo
  import ald_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  st_ent_t          push_ent,
  input  logic             pop,
  output logic             full,
  output logic             empty,
  output st_ent_t          head,
  output logic [DEPTH-1:0] slot_vld,
  output st_ent_t          slot [DEPTH],
  output logic [CNT_W-1:0] count
);
  st_ent_t          mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [DEPTH-1:0] vld_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      vld_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop) begin
        vld_q[rd_ptr] <= 1'b0;
        rd_ptr        <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
      if (push) begin
        vld_q[wr_ptr] <= 1'b1;
        wr_ptr        <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      end
      unique case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_ent;
  end

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign head     = mem[rd_ptr];
  assign slot_vld = vld_q;
  assign count    = cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign slot[i] = mem[i];
  end
endmodule

// File: rtl/ald_alias_match.sv
module ald_alias_match
  import ald_pkg::*;
(
  input  logic              ent_vld,
  input  st_ent_t           ent,
  input  logic [OFF_W-1:0]  ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  output logic              hit
);
  logic             wide;
  logic [OFF_W-1:0] mask;
  logic [OFF_W-1:0] diff;

  always_comb begin
    wide = (ld_size == SZ_DWORD) || (ent.size == SZ_DWORD);
    mask = wide ? MASK_DWORD : MASK_WORD;
    diff = (ld_addr ^ ent.addr) & mask;
    hit  = ent_vld && (diff == '0);
  end
endmodule

// File: rtl/ald_age_ctr.sv
module ald_age_ctr #(
  parameter int AGE_W = 2,
  localparam logic [AGE_W-1:0] AGE_MAX = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             ld_new,
  output logic [AGE_W-1:0] age_now
);
  logic [AGE_W-1:0] age_q;

  assign age_now = ld_new ? AGE_W'(1) : age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (ld_valid) begin
      age_q <= (age_now == AGE_MAX) ? AGE_MAX : age_now + AGE_W'(1);
    end
  end
endmodule

// File: rtl/ald_guard.sv
module ald_guard
  import ald_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AGE_W = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic              ld_new,
  input  logic [OFF_W-1:0]  ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic              st_in_valid,
  output logic              st_in_ready,
  input  logic [OFF_W-1:0]  st_in_addr,
  input  logic [SIZE_W-1:0] st_in_size,
  output logic              st_out_valid,
  input  logic              st_out_ready,
  output logic [OFF_W-1:0]  st_out_addr,
  output logic [SIZE_W-1:0] st_out_size,
  output logic              ld_cache_go,
  output logic              ld_stall,
  output logic              ld_cancel
);
  logic             q_full, q_empty;
  st_ent_t          q_head;
  logic [DEPTH-1:0] q_vld;
  st_ent_t          q_slot [DEPTH];
  logic [CNT_W-1:0] q_count;
  logic             do_push, do_pop;
  st_ent_t          in_ent;
  logic [DEPTH-1:0] hit_vec;
  logic             any_hit;
  logic [AGE_W-1:0] age_now;
  logic             late_hit;
  logic             cancel_q;

  assign in_ent  = '{addr: st_in_addr, size: st_in_size};
  assign do_push = st_in_valid && st_in_ready;
  assign do_pop  = st_out_valid && st_out_ready;

  ald_store_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (do_push),
    .push_ent (in_ent),
    .pop      (do_pop),
    .full     (q_full),
    .empty    (q_empty),
    .head     (q_head),
    .slot_vld (q_vld),
    .slot     (q_slot),
    .count    (q_count)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    ald_alias_match u_match (
      .ent_vld (q_vld[i]),
      .ent     (q_slot[i]),
      .ld_addr (ld_addr),
      .ld_size (ld_size),
      .hit     (hit_vec[i])
    );
  end

  assign any_hit = |hit_vec;

  ald_age_ctr #(.AGE_W(AGE_W)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_new   (ld_new),
    .age_now  (age_now)
  );

  always_comb begin
    late_hit     = ld_valid && any_hit && (age_now == AGE_W'(1));
    ld_stall     = ld_valid && any_hit;
    ld_cache_go  = ld_valid && (!any_hit || late_hit);
    st_out_valid = !q_empty && !ld_cache_go;
    st_in_ready  = !q_full;
    st_out_addr  = q_head.addr;
    st_out_size  = q_head.size;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cancel_q <= 1'b0;
    else        cancel_q <= late_hit;
  end

  assign ld_cancel = cancel_q;
endmodule

// File: rtl/ald_guard_chk.sv
module ald_guard_chk #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_new,
  input logic             st_in_ready,
  input logic             st_out_valid,
  input logic             st_out_ready,
  input logic [11:0]      st_out_addr,
  input logic             ld_cache_go,
  input logic             ld_stall,
  input logic             ld_cancel,
  input logic [CNT_W-1:0] q_count
);
  a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CNT_W'(DEPTH)) |-> !st_in_ready);

  a_r3_head_held_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (st_out_valid && !st_out_ready) |=> $stable(st_out_addr));

  a_r3_single_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_cache_go && st_out_valid));

  a_r8_cancel_after_late: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stall && ld_cache_go) |=> ld_cancel);

  a_r9_stall_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> (q_count != '0));

  a_r10_cancel_once: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cancel && !ld_new) |=> !ld_cancel);
endmodule

bind ald_guard ald_guard_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ld_new       (ld_new),
  .st_in_ready  (st_in_ready),
  .st_out_valid (st_out_valid),
  .st_out_ready (st_out_ready),
  .st_out_addr  (st_out_addr),
  .ld_cache_go  (ld_cache_go),
  .ld_stall     (ld_stall),
  .ld_cancel    (ld_cancel),
  .q_count      (q_count)
);

// File: tb/ald_guard_bench.sv
module ald_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid, ld_new, st_in_valid, st_out_ready;
  logic [11:0] ld_addr, st_in_addr;
  logic [1:0]  ld_size, st_in_size;
  logic        st_in_ready, st_out_valid, ld_cache_go, ld_stall, ld_cancel;
  logic [11:0] st_out_addr;
  logic [1:0]  st_out_size;

  always #2.5 clk = ~clk;

  ald_guard u_ald_guard (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_new(ld_new), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_in_valid(st_in_valid), .st_in_ready(st_in_ready),
    .st_in_addr(st_in_addr), .st_in_size(st_in_size),
    .st_out_valid(st_out_valid), .st_out_ready(st_out_ready),
    .st_out_addr(st_out_addr), .st_out_size(st_out_size),
    .ld_cache_go(ld_cache_go), .ld_stall(ld_stall), .ld_cancel(ld_cancel)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [11:0] m_addr[$];
  logic [1:0]  m_size[$];
  int          m_age = 0;
  bit          m_cancel = 0;
  bit e_go, e_stall, e_sov, e_srdy;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_alias();
    for (int i = 0; i < m_addr.size(); i++) begin
      int mask = (ld_size == 2'd3 || m_size[i] == 2'd3) ? 'hFF8 : 'hFFC;
      if (((int'(ld_addr) ^ int'(m_addr[i])) & mask) == 0) return 1;
    end
    return 0;
  endfunction

  // settle combinational outputs and compare with the model
  task automatic settle();
    int eage;
    bit al;
    #1;
    al      = ld_valid && m_alias();
    eage    = ld_new ? 1 : m_age;
    e_stall = al;
    e_go    = ld_valid && (!al || eage == 1);
    e_sov   = (m_addr.size() > 0) && !e_go;
    e_srdy  = m_addr.size() < 4;
    chk(st_in_ready == e_srdy, "R2", "st_in_ready", st_in_ready, e_srdy);
    chk(st_out_valid == e_sov, "R3", "st_out_valid", st_out_valid, e_sov);
    if (e_sov) begin
      chk(st_out_addr == m_addr[0], "R2", "st_out_addr", st_out_addr, m_addr[0]);
      chk(st_out_size == m_size[0], "R2", "st_out_size", st_out_size, m_size[0]);
    end
    chk(ld_cache_go == e_go, "R6", "ld_cache_go", ld_cache_go, e_go);
    chk(ld_stall == e_stall, "R9", "ld_stall", ld_stall, e_stall);
    chk(ld_cancel == m_cancel, "R8", "ld_cancel", ld_cancel, m_cancel);
  endtask

  task automatic tick();
    int eage;
    eage = ld_new ? 1 : m_age;
    @(posedge clk);
    if (e_sov && st_out_ready) begin
      void'(m_addr.pop_front());
      void'(m_size.pop_front());
    end
    if (st_in_valid && e_srdy) begin
      m_addr.push_back(st_in_addr);
      m_size.push_back(st_in_size);
    end
    m_cancel = e_stall && e_go;
    if (ld_valid) m_age = (eage >= 3) ? 3 : eage + 1;
    @(negedge clk);
  endtask

  task automatic idle_in();
    ld_valid = 0; ld_new = 0; ld_addr = '0; ld_size = '0;
    st_in_valid = 0; st_in_addr = '0; st_in_size = '0; st_out_ready = 1;
  endtask

  task automatic push_store(input logic [11:0] a, input logic [1:0] s);
    idle_in();
    st_in_valid = 1; st_in_addr = a; st_in_size = s; st_out_ready = 0;
    settle(); tick();
    idle_in();
  endtask

  task automatic flush();
    idle_in();
    for (int i = 0; i < 8; i++) begin settle(); tick(); end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    bit prev_left;
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(st_in_ready == 1, "R1", "st_in_ready", st_in_ready, 1);
    chk(st_out_valid == 0 && ld_stall == 0 && ld_cancel == 0 && ld_cache_go == 0,
        "R1", "outputs", {st_out_valid, ld_stall, ld_cancel, ld_cache_go}, 0);
    @(negedge clk);

    // R4 late path: store 0x2000 (4B) vs load 0x3003 (1B)
    push_store(12'h000, 2'd2);  // offset of 0x2000
    ld_valid = 1; ld_new = 1; ld_addr = 12'h003; ld_size = 2'd0; st_out_ready = 0;
    settle();
    chk(ld_stall && ld_cache_go && !st_out_valid, "R8", "late path",
        {ld_stall, ld_cache_go, st_out_valid}, 3'b110);
    chk(ld_stall == 1, "R4", "0x2000/0x3003 alias", ld_stall, 1);
    tick();
    ld_new = 0;
    settle();
    chk(ld_cancel == 1, "R8", "cancel next cycle", ld_cancel, 1);
    chk(st_out_valid && !ld_cache_go, "R7", "store drains after cancel",
        {st_out_valid, ld_cache_go}, 2'b10);
    tick();  // store missed: held
    settle();
    chk(ld_cancel == 0, "R10", "cancel once", ld_cancel, 0);
    chk(ld_stall == 1, "R9", "stall held by missing store", ld_stall, 1);
    st_out_ready = 1;
    settle(); tick();
    settle();
    chk(ld_stall == 0 && ld_cache_go == 1, "R9", "release after drain",
        {ld_stall, ld_cache_go}, 2'b01);
    tick();
    flush();

    // R4 no alias 0x2000 vs 0x2020: bypass
    push_store(12'h000, 2'd2);
    ld_valid = 1; ld_new = 1; ld_addr = 12'h020; ld_size = 2'd2; st_out_ready = 0;
    settle();
    chk(ld_stall == 0 && ld_cache_go == 1, "R6", "bypass 0x2020",
        {ld_stall, ld_cache_go}, 2'b01);
    tick();
    flush();

    // R5: 8-byte store at 0x000 vs 4-byte load at 0x004 -> alias
    push_store(12'h000, 2'd3);
    ld_valid = 1; ld_new = 1; ld_addr = 12'h004; ld_size = 2'd2; st_out_ready = 0;
    settle();
    chk(ld_stall == 1, "R5", "dword mask alias", ld_stall, 1);
    tick(); ld_new = 0; st_out_ready = 1; settle(); tick();
    flush();
    // R4 counterpart: both 4 bytes, 0x000 vs 0x004 -> no alias
    push_store(12'h000, 2'd2);
    ld_valid = 1; ld_new = 1; ld_addr = 12'h004; ld_size = 2'd2; st_out_ready = 0;
    settle();
    chk(ld_stall == 0, "R4", "word mask no alias", ld_stall, 0);
    tick();
    flush();

    // R7 early path: load waits (external hold), then aliasing store arrives
    ld_valid = 1; ld_new = 1; ld_addr = 12'h100; ld_size = 2'd2; st_out_ready = 0;
    settle(); tick();
    ld_new = 0; st_in_valid = 1; st_in_addr = 12'h102; st_in_size = 2'd1;
    settle(); tick();
    st_in_valid = 0; st_out_ready = 1;
    settle();
    chk(ld_stall && !ld_cache_go && st_out_valid, "R7", "early block",
        {ld_stall, ld_cache_go, st_out_valid}, 3'b101);
    tick();
    settle();
    chk(ld_cancel == 0, "R7", "no cancel on early path", ld_cancel, 0);
    tick();
    flush();

    // R2 fill to capacity, overflow push rejected, FIFO order
    for (int i = 0; i < 5; i++) push_store(12'(16 * i + 8), 2'(i % 4));
    idle_in(); st_out_ready = 0;
    settle();
    chk(st_in_ready == 0, "R2", "full", st_in_ready, 0);
    chk(st_out_addr == 12'h008, "R2", "head order", st_out_addr, 12'h008);
    flush();

    // random traffic against the model
    prev_left = 1;
    for (int n = 0; n < 4000; n++) begin
      bit keep;
      keep = !prev_left;
      st_in_valid  = ($urandom % 3) == 0;
      st_in_addr   = 12'($urandom % 64);
      st_in_size   = 2'($urandom % 4);
      st_out_ready = ($urandom % 4) != 0;
      if (keep) begin
        ld_new = 0;
      end else begin
        ld_valid = ($urandom % 4) != 0;
        ld_new   = ld_valid;
        ld_addr  = 12'($urandom % 64);
        ld_size  = 2'($urandom % 4);
        if (!ld_valid) ld_new = 0;
      end
      settle();
      // leave unless stalled; sometimes linger to reach the early path
      prev_left = !ld_valid || (!e_stall && ($urandom % 3) != 0);
      tick();
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule